// File: doc/BRIEF.md
# Interrupt Mask and Sticky Status Register Group

This block is the interrupt control part of a memory-mapped serial controller. It keeps a per-source interrupt mask and a per-source sticky raw status. The surrounding queues, shifter and timer report conditions as single-cycle event pulses, one wire per source. Each pulse sets its status bit, and the bit stays set until software clears it. The block drives one level-sensitive interrupt line. The line is high while any source is both pending and unmasked.

Software never writes the mask directly. It writes ones to a set register to unmask sources, and ones to a separate clear register to mask them. It reads the result from a read-only mask view. Pending bits are cleared by writing ones to the status register. A word-addressed read/write port reaches all four registers. Reads are combinational from the current register contents and have no side effects.

The register select is a small enumerated decode with the states SEL_NONE, SEL_SET, SEL_CLR, SEL_VIEW and SEL_STAT. It is chosen from the word address each cycle. There is no sequencing between states, so every access resolves in the cycle in which it is presented.

Top module: `irq_ctl_top`

## Requirements
- R1: After reset the mask view and the status register read zero, and `irq_o` is low.
- R2: A one on `evt_i[k]` sets status bit k. The source order is: 0 rx trigger, 1 rx empty, 2 rx full, 3 tx empty, 4 tx full, 5 rx overflow, 6 framing error, 7 parity error, 8 rx timeout, 9 modem status change, 10 tx trigger, 11 tx nearly full, 12 tx overflow.
- R3: A write to word address 2 (the set register) ORs `wdata_i[12:0]` into the mask.
- R4: A write to word address 3 (the clear register) clears every mask bit where `wdata_i` holds a one.
- R5: A write to word address 4 (the mask view) has no effect. Reading that address returns the mask in bits 12:0.
- R6: A write to word address 5 (status) clears each status bit where `wdata_i` holds a one. Reading that address returns the status in bits 12:0 and changes nothing.
- R7: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R8: `irq_o` is registered. It is high in the cycle after the mask and the status share a set bit, and low in the cycle after they share none.
- R9: Reads of the set register, the clear register and every unmapped address return zero.
- R10: Status bits are raw. Changing the mask neither sets nor clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | 4 | Word address for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, zero-extended |
| evt_i | input | 13 | One-cycle event pulses, one per source |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that `wr_en_i` and `addr_i` present at most one register access per cycle. They also assume that events are plain pulses sampled on the clock edge. The set register and the clear register can therefore never both be written in one cycle.

The bench drives every input on the falling edge and holds it through the following rising edge, so each access and each pulse is seen exactly once. It mixes directed sequences with a long pseudo-random run whose addresses include the unmapped range. A behavioural model tracks the mask, the status and the delayed request, and it is compared with the outputs every cycle.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
    localparam int SRC_N  = 13;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    // word addresses of the four registers
    localparam logic [ADDR_W-1:0] WA_SET  = 4'd2;
    localparam logic [ADDR_W-1:0] WA_CLR  = 4'd3;
    localparam logic [ADDR_W-1:0] WA_VIEW = 4'd4;
    localparam logic [ADDR_W-1:0] WA_STAT = 4'd5;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SET,
        SEL_CLR,
        SEL_VIEW,
        SEL_STAT
    } reg_sel_e;
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import irq_ctl_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr_i,
    output reg_sel_e      sel_o
);
    always_comb begin
        unique case (addr_i)
            AW'(WA_SET):  sel_o = SEL_SET;
            AW'(WA_CLR):  sel_o = SEL_CLR;
            AW'(WA_VIEW): sel_o = SEL_VIEW;
            AW'(WA_STAT): sel_o = SEL_STAT;
            default:      sel_o = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int N = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we_i,
    input  logic         clr_we_i,
    input  logic [N-1:0] bits_i,
    output logic [N-1:0] mask_o
);
    logic [N-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        mask_q <= '0;
        else if (set_we_i) mask_q <= mask_q | bits_i;
        else if (clr_we_i) mask_q <= mask_q & ~bits_i;
    end

    assign mask_o = mask_q;

    AST_SET_ORS_IN: assert property (@(posedge clk) disable iff (!rst_n)
        set_we_i |=> ((mask_q & $past(bits_i)) == $past(bits_i))); // R3
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((mask_q & $past(bits_i)) == '0)); // R4
    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_we_i || clr_we_i) |=> $stable(mask_q)); // R5
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
    parameter int N = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         w1c_we_i,
    input  logic [N-1:0] bits_i,
    input  logic [N-1:0] evt_i,
    output logic [N-1:0] stat_o
);
    logic [N-1:0] stat_q;
    logic [N-1:0] clr_v;

    assign clr_v = w1c_we_i ? bits_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_v) | evt_i;
    end

    assign stat_o = stat_q;

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i))); // R7
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(evt_i)) == '0)); // R2
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_v & ~evt_i)) |=> ((stat_q & $past(clr_v & ~evt_i)) == '0)); // R6
endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
    import irq_ctl_pkg::*;
#(
    parameter int N  = SRC_N,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    input  logic [N-1:0]  evt_i,
    output logic          irq_o
);
    localparam int PAD = DW - N;

    reg_sel_e     sel;
    logic [N-1:0] wbits;
    logic [N-1:0] mask;
    logic [N-1:0] stat;
    logic         irq_q;

    assign wbits = wdata_i[N-1:0];

    irq_addr_decode #(.AW(AW)) u_dec (
        .addr_i (addr_i),
        .sel_o  (sel)
    );

    irq_mask_reg #(.N(N)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we_i (wr_en_i && (sel == SEL_SET)),
        .clr_we_i (wr_en_i && (sel == SEL_CLR)),
        .bits_i   (wbits),
        .mask_o   (mask)
    );

    irq_status_reg #(.N(N)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .w1c_we_i (wr_en_i && (sel == SEL_STAT)),
        .bits_i   (wbits),
        .evt_i    (evt_i),
        .stat_o   (stat)
    );

    always_comb begin
        unique case (sel)
            SEL_VIEW: rdata_o = {{PAD{1'b0}}, mask};
            SEL_STAT: rdata_o = {{PAD{1'b0}}, stat};
            default:  rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(mask & stat);
    end

    assign irq_o = irq_q;

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(mask & stat)))); // R8
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != SEL_VIEW && sel != SEL_STAT) |-> (rdata_o == '0)); // R9
    AST_MASK_NO_TOUCH_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (sel == SEL_SET || sel == SEL_CLR) && evt_i == '0) |=> $stable(stat)); // R10
endmodule

// File: tb/irq_ctl_top_bench.sv
module irq_ctl_top_bench;
    localparam int N = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [N-1:0] evt = '0;
    logic        irq;

    int compared = 0;
    int mismatched = 0;

    logic [N-1:0] m_mask = '0;
    logic [N-1:0] m_stat = '0;
    bit           m_irq  = 1'b0;

    always #5 clk = ~clk;

    irq_ctl_top u_irq_ctl_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .evt_i   (evt),
        .irq_o   (irq)
    );

    function automatic logic [31:0] model_read(input logic [3:0] a);
        if (a == 4'd4) return {19'd0, m_mask};
        if (a == 4'd5) return {19'd0, m_stat};
        return 32'd0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One bus cycle: drive on the falling edge, check the combinational
    // read, let the rising edge pass, update the model, check the request line.
    task automatic step(input string tag, input bit we, input logic [3:0] a,
                        input logic [31:0] d, input logic [N-1:0] e);
        logic [N-1:0] clr;
        wr_en = we; addr = a; wdata = d; evt = e;
        #1;
        check(tag, rdata, model_read(a));
        @(posedge clk);
        m_irq = |(m_mask & m_stat);
        clr = (we && a == 4'd5) ? d[N-1:0] : '0;
        m_stat = (m_stat & ~clr) | e;
        if (we && a == 4'd2) m_mask = m_mask | d[N-1:0];
        else if (we && a == 4'd3) m_mask = m_mask & ~d[N-1:0];
        @(negedge clk);
        check("R8 irq", {31'd0, irq}, {31'd0, m_irq});
    endtask

    initial begin
        #(200000 * 10);
        mismatched++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 irq at reset", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        step("R1 mask view", 0, 4'd4, 0, '0);
        step("R1 status", 0, 4'd5, 0, '0);
        // R2: walk each source onto its own bit, read back, clear
        for (int k = 0; k < N; k++) begin
            step("R2 event", 0, 4'd5, 0, N'(1) << k);
            step("R2 bit position", 0, 4'd5, 0, '0);
            step("R6 clear", 1, 4'd5, 32'h1FFF, '0);
        end
        step("R6 empty", 0, 4'd5, 0, '0);
        // R3 set register
        step("R3 set", 1, 4'd2, 32'h000F, '0);
        step("R3 set more", 1, 4'd2, 32'hFFFF_E300, '0);
        step("R3 view", 0, 4'd4, 0, '0);
        // R4 clear register
        step("R4 clr", 1, 4'd3, 32'h0105, '0);
        step("R4 view", 0, 4'd4, 0, '0);
        // R5 view register ignores writes
        step("R5 write view", 1, 4'd4, 32'h1FFF, '0);
        step("R5 view unchanged", 0, 4'd4, 0, '0);
        step("R5 write view zero", 1, 4'd4, 32'h0, '0);
        step("R5 view unchanged", 0, 4'd4, 0, '0);
        // R8 masked and unmasked events
        step("R8 masked event", 0, 4'd5, 0, 13'h0010);
        step("R8 no irq", 0, 4'd5, 0, '0);
        step("R8 unmasked event", 0, 4'd5, 0, 13'h0002);
        step("R8 irq rises", 0, 4'd5, 0, '0);
        step("R6 read no side effect", 0, 4'd5, 0, '0);
        step("R6 partial clear", 1, 4'd5, 32'h0002, '0);
        step("R8 irq falls", 0, 4'd5, 0, '0);
        // R7 event beats clear in the same cycle
        step("R7 same cycle", 1, 4'd5, 32'h1FFF, 13'h0402);
        step("R7 bits kept", 0, 4'd5, 0, '0);
        // R10 mask changes leave status alone
        step("R10 mask all off", 1, 4'd3, 32'h1FFF, '0);
        step("R10 status kept", 0, 4'd5, 0, '0);
        step("R10 mask all on", 1, 4'd2, 32'h1FFF, '0);
        step("R10 status kept", 0, 4'd5, 0, '0);
        // R9 write-only and unmapped reads
        step("R9 set reads zero", 0, 4'd2, 0, '0);
        step("R9 clr reads zero", 0, 4'd3, 0, '0);
        step("R9 unmapped", 0, 4'd0, 0, '0);
        step("R9 unmapped", 1, 4'd15, 32'h1FFF, '0);
        step("R9 unmapped", 0, 4'd7, 0, '0);
        step("R6 status after unmapped write", 0, 4'd5, 0, '0);
        // mixed pseudo-random traffic
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom;
            step("R2 R3 R4 R6 R7 random", r[0] & r[1], r[7:4], $urandom,
                 (r[9:8] == 2'b00) ? N'($urandom) : '0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule